// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-bit storage register with four clocked behaviours: keep its value, move its contents one place toward the top bit, move them one place toward the bottom bit, or take a whole word at once. Parallel data enters and leaves through a single shared bus. The tri-state bus is split here into an input vector, an output vector and a drive-enable, so the block can sit inside a synthesized design and the pad or bus ring can build the physical tri-state. Two serial inputs feed the bit that is vacated during a shift. Both end bits are always visible on dedicated outputs, so several registers can be chained into a longer one.

A two-bit mode input chooses the behaviour. Two active-low enables decide whether the register drives the shared bus. Choosing the load mode releases the bus regardless of the enables, so an outside agent can place the word that is captured at the next rising edge. An asynchronous active-low clear empties the register at any moment, whatever the enables and the mode.

The block has no data stream with flow control: every rising edge performs the selected operation. The valid/ready convention of the project style therefore does not apply, and there is no back-pressure.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `clr_n` is low, every register bit is 0 at once without waiting for a clock edge, whatever the mode, the enables or `port_in`, and `clk` edges have no effect during that time.
- R2: With `mode_sel` = 2'b00, a rising edge leaves the register unchanged.
- R3: With `mode_sel` = 2'b01, a rising edge moves bit i into bit i+1 for i = 0..6 and places `ser_in_lo` in bit 0.
- R4: With `mode_sel` = 2'b10, a rising edge moves bit i+1 into bit i for i = 0..6 and places `ser_in_hi` in bit 7.
- R5: With `mode_sel` = 2'b11, a rising edge copies `port_in` into all eight bits.
- R6: While `mode_sel` = 2'b11, `port_drive` is 0 and `port_out` is all zeros, even when both enables are low.
- R7: `port_drive` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 2'b11. `port_out` then equals the register, and it is all zeros whenever `port_drive` is 0.
- R8: `tap_lo` always equals bit 0 and `tap_hi` always equals bit 7 of the register, whatever the enables and the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operation: 00 keep, 01 move toward bit 7, 10 move toward bit 0, 11 parallel load |
| oe_a_n | input | 1 | First bus enable, active low |
| oe_b_n | input | 1 | Second bus enable, active low |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 in mode 01 |
| ser_in_hi | input | 1 | Serial bit that enters bit 7 in mode 10 |
| port_in | input | 8 | Value on the shared bus, captured in mode 11 |
| port_out | output | 8 | Register value offered to the shared bus |
| port_drive | output | 1 | High when the block drives the shared bus |
| tap_lo | output | 1 | Bit 0 of the register, for chaining |
| tap_hi | output | 1 | Bit 7 of the register, for chaining |

## Verification
Every cycle, the assertions check the next-state rule of each mode (keep, the two shift directions and the parallel capture), that the bus is released whenever the load mode is selected, that the bus carries the register value with both enables low whenever it is driven, and that the register is empty during clear. Only the bench's scenarios show a clear that arrives between clock edges taking effect at once, with the bus both enabled and disabled. They also show the clear holding the register at zero across an edge that would otherwise load all ones, and the end taps following the register while the bus is disabled. Long mixed runs of random modes and enables are compared against a behavioural model in the bench.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } bsr_mode_e;

  typedef struct packed {
    logic keep;
    logic up;
    logic down;
    logic load;
  } bsr_sel_t;

endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
  import bsr_pkg::*;
(
  input  logic [1:0] mode_sel,
  output bsr_sel_t   sel
);

  always_comb begin
    sel = '0;
    unique case (bsr_mode_e'(mode_sel))
      MODE_KEEP: sel.keep = 1'b1;
      MODE_UP:   sel.up   = 1'b1;
      MODE_DOWN: sel.down = 1'b1;
      MODE_LOAD: sel.load = 1'b1;
      default:   sel.keep = 1'b1;
    endcase
  end

endmodule

// File: rtl/bsr_bit_cell.sv
module bsr_bit_cell
  import bsr_pkg::*;
(
  input  logic     clk,
  input  logic     clr_n,
  input  bsr_sel_t sel,
  input  logic     from_below,
  input  logic     from_above,
  input  logic     par_d,
  output logic     q
);

  logic d;

  always_comb begin
    d = q;
    if (sel.up)   d = from_below;
    if (sel.down) d = from_above;
    if (sel.load) d = par_d;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/bsr_port_gate.sv
module bsr_port_gate #(
  parameter int WIDTH = 8
) (
  input  logic             load_sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] port_out,
  output logic             port_drive
);

  logic enables_on;

  assign enables_on = ~oe_a_n & ~oe_b_n;
  assign port_drive = enables_on & ~load_sel;
  assign port_out   = port_drive ? q : '0;

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode_sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] port_out,
  output logic             port_drive,
  output logic             tap_lo,
  output logic             tap_hi
);

  localparam int MSB = WIDTH - 1;

  bsr_sel_t       sel;
  logic [MSB:0]   q;

  bsr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .sel      (sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic below, above;
    if (i == 0) begin : g_first
      assign below = ser_in_lo;
    end else begin : g_inner_lo
      assign below = q[i-1];
    end
    if (i == MSB) begin : g_last
      assign above = ser_in_hi;
    end else begin : g_inner_hi
      assign above = q[i+1];
    end
    bsr_bit_cell u_cell (
      .clk        (clk),
      .clr_n      (clr_n),
      .sel        (sel),
      .from_below (below),
      .from_above (above),
      .par_d      (port_in[i]),
      .q          (q[i])
    );
  end

  bsr_port_gate #(.WIDTH(WIDTH)) u_gate (
    .load_sel   (sel.load),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .q          (q),
    .port_out   (port_out),
    .port_drive (port_drive)
  );

  assign tap_lo = q[0];
  assign tap_hi = q[MSB];

  // Register is empty whenever clear is low at a clock edge (R1)
  always @(posedge clk) begin
    if (!clr_n) begin
      assert_clear_R1: assert (q == '0)
        else $error("clear did not empty the register");
    end
  end

  assert_keep_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == MODE_KEEP) |=> $stable(q));

  assert_up_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == MODE_UP) |=> (q == {$past(q[MSB-1:0]), $past(ser_in_lo)}));

  assert_down_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == MODE_DOWN) |=> (q == {$past(ser_in_hi), $past(q[MSB:1])}));

  assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == MODE_LOAD) |=> (q == $past(port_in)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == MODE_LOAD) |-> (!port_drive && port_out == '0));

  assert_drive_R7: assert property (@(posedge clk) disable iff (!clr_n)
    port_drive |-> (port_out == q && !oe_a_n && !oe_b_n));

endmodule

// File: tb/bidir_shift_reg_tb_top.sv
module bidir_shift_reg_tb_top;

  typedef struct {
    string      tag;
    logic [7:0] out;
    logic       drive;
    logic       lo;
    logic       hi;
  } exp_t;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       oe_a_n = 1'b1;
  logic       oe_b_n = 1'b1;
  logic       ser_in_lo = 1'b0;
  logic       ser_in_hi = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic [7:0] port_out;
  logic       port_drive;
  logic       tap_lo;
  logic       tap_hi;

  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 1'b0;
  logic [7:0] model = 8'h00;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  bidir_shift_reg dut_i (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode_sel   (mode_sel),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .ser_in_lo  (ser_in_lo),
    .ser_in_hi  (ser_in_hi),
    .port_in    (port_in),
    .port_out   (port_out),
    .port_drive (port_drive),
    .tap_lo     (tap_lo),
    .tap_hi     (tap_hi)
  );

  function automatic exp_t make_exp(string tag, logic [7:0] r, logic [1:0] m,
                                    logic a_n, logic b_n);
    exp_t e;
    e.tag   = tag;
    e.drive = !a_n && !b_n && (m != 2'b11);
    e.out   = e.drive ? r : 8'h00;
    e.lo    = r[0];
    e.hi    = r[7];
    return e;
  endfunction

  task automatic compare(exp_t e);
    vectors++;
    if (port_out !== e.out || port_drive !== e.drive ||
        tap_lo !== e.lo || tap_hi !== e.hi) begin
      miscompares++;
      $display("FAIL %s: out=%h drive=%b lo=%b hi=%b expected out=%h drive=%b lo=%b hi=%b",
               e.tag, port_out, port_drive, tap_lo, tap_hi,
               e.out, e.drive, e.lo, e.hi);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic apply(string tag, logic [1:0] m, logic a_n, logic b_n,
                       logic s_lo, logic s_hi, logic [7:0] d);
    @(negedge clk);
    mode_sel = m; oe_a_n = a_n; oe_b_n = b_n;
    ser_in_lo = s_lo; ser_in_hi = s_hi; port_in = d;
    case (m)
      2'b00: model = model;
      2'b01: model = {model[6:0], s_lo};
      2'b10: model = {s_hi, model[7:1]};
      default: model = d;
    endcase
    sb_q.push_back(make_exp(tag, model, m, a_n, b_n));
  endtask

  // Monitor: compares after every rising edge that has an expected item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  // Clear between edges, held across one edge that would load all ones (R1)
  task automatic mid_clear(logic a_n, logic b_n);
    @(negedge clk);
    mode_sel = 2'b11; port_in = 8'hFF; oe_a_n = a_n; oe_b_n = b_n;
    #1 clr_n = 1'b0;
    #0.5 compare(make_exp("R1 immediate clear", 8'h00, 2'b11, a_n, b_n));
    @(posedge clk);
    #1 compare(make_exp("R1 clear beats clock", 8'h00, 2'b11, a_n, b_n));
    @(negedge clk);
    mode_sel = 2'b00;
    #0.5 compare(make_exp("R1 cleared while keeping", 8'h00, 2'b00, a_n, b_n));
    clr_n = 1'b1;
    model = 8'h00;
  endtask

  initial begin
    #1 compare(make_exp("R1 reset state", 8'h00, 2'b00, 1'b1, 1'b1));
    @(negedge clk);
    clr_n = 1'b1;

    apply("R5 load enabled", 2'b11, 0, 0, 0, 0, 8'hA5);
    apply("R6 load releases bus", 2'b11, 0, 0, 0, 0, 8'h3C);
    apply("R2 keep visible", 2'b00, 0, 0, 1, 1, 8'hFF);
    apply("R2 keep again", 2'b00, 0, 0, 0, 1, 8'h00);
    apply("R7 enable a off", 2'b00, 1, 0, 0, 0, 8'h00);
    apply("R7 enable b off", 2'b00, 0, 1, 0, 0, 8'h00);
    apply("R8 taps while disabled", 2'b01, 1, 1, 1, 0, 8'h00);
    apply("R3 shift up in 0", 2'b01, 0, 0, 0, 1, 8'h00);
    apply("R3 shift up in 1", 2'b01, 0, 0, 1, 0, 8'h00);
    apply("R3 shift up in 1", 2'b01, 0, 0, 1, 0, 8'h00);
    apply("R4 shift down in 1", 2'b10, 0, 0, 0, 1, 8'h00);
    apply("R4 shift down in 0", 2'b10, 0, 0, 1, 0, 8'h00);
    apply("R4 shift down in 1", 2'b10, 0, 0, 0, 1, 8'h00);
    apply("R8 taps shift disabled", 2'b10, 1, 0, 0, 1, 8'h00);
    apply("R5 load while disabled", 2'b11, 1, 1, 0, 0, 8'h81);
    apply("R7 read load result", 2'b00, 0, 0, 0, 0, 8'h00);

    mid_clear(1'b0, 1'b0);
    apply("R2 after clear enabled", 2'b00, 0, 0, 0, 0, 8'h00);
    apply("R5 reload", 2'b11, 0, 0, 0, 0, 8'h5A);
    mid_clear(1'b1, 1'b1);
    apply("R7 after clear disabled", 2'b00, 0, 0, 0, 0, 8'h00);

    for (int k = 0; k < 200; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      apply("R7 mixed", m, 1'($urandom_range(0, 1)) & 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)) & 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            8'($urandom_range(0, 255)));
    end

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule